// File: doc/BRIEF.md
# Decode-Stage Branch and Link Controller

This block settles branches while the instruction sits in the decode stage of a five-stage pipeline with one branch delay slot. It holds the decode pipeline register itself: an instruction class, a condition code, a 16-bit offset, the instruction's PC and its normally decoded write enable and destination. From these and the two source operands, already forwarded by the caller, it computes the comparison, the taken flag, the branch target and the next PC. It also produces the write enable, destination and PC+8 data select that travel on to the execute register, and a clear for its own decode register.

Four instruction classes are recognised. A plain instruction does not branch and passes its write controls through. A branch-and-link always writes the return address to register 31. A conditional-link branch writes register 31 only when its condition holds. A nullifying branch discards its delay slot when the branch falls through. That discard happens one edge later: the clear stops the slot from being loaded and leaves a bubble in decode. While the pipeline is stalled, the operands seen in decode may be stale, so the clear is held off until the stall ends.

The decode register is tracked by a two-state machine. In state BUBBLE the stage holds no instruction. In state LIVE it holds a valid one. The transitions are:
- LOAD (BUBBLE to LIVE): no stall and a valid fetched instruction.
- DRAIN (LIVE to BUBBLE): no stall and no valid fetch.
- NULLIFY (LIVE to BUBBLE): clear asserted.
- HOLD (either state to itself): stall asserted, or no change.
- RESET (any state to BUBBLE): synchronous reset.

Top module: `bl_decode_ctrl`

## Requirements
- R1: After synchronous reset the decode stage is empty: br_taken, e_rf_we, e_wb_pc8 and d_flush are all 0.
- R2: The comparison uses cond code 00 for rs equal to rt, 01 for rs not equal to rt, 10 for rs negative as a signed value, and 11 for never true.
- R3: br_target equals the instruction PC + 4 plus the sign-extended 16-bit offset shifted left by 2. next_pc equals br_target when br_taken is 1, and PC + 4 otherwise.
- R4: For class 01 (branch-and-link), e_rf_we is 1, e_rf_dst is 31 and e_wb_pc8 is 1, whatever the comparison gives. br_taken equals the comparison.
- R5: For class 10 (conditional link), e_rf_we equals the comparison, e_rf_dst is 31 and e_wb_pc8 is 1. br_taken equals the comparison.
- R6: For class 00 (plain), br_taken and e_wb_pc8 are 0, and e_rf_we and e_rf_dst equal the latched write enable and destination.
- R7: For class 11 (nullifying), d_flush is 1 exactly when the comparison is false and stall is 0. e_rf_we and e_rf_dst pass through from the latch, and e_wb_pc8 is 0.
- R8: d_flush is never 1 while stall is 1.
- R9: After a cycle with d_flush at 1, the decode stage is empty, even if a valid instruction was offered by fetch.
- R10: While stall is 1 and d_flush is 0, the decode register keeps its contents.
- R11: While the decode stage is empty, br_taken, e_rf_we, e_wb_pc8 and d_flush are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Pipeline stall: hold decode and block the clear |
| f_valid | input | 1 | Fetch offers a valid instruction |
| f_kind | input | 2 | Class of the fetched instruction (00 plain, 01 link, 10 conditional link, 11 nullifying) |
| f_cond | input | 2 | Condition code of the fetched instruction |
| f_offset | input | 16 | Branch offset in words |
| f_pc | input | 32 | PC of the fetched instruction |
| f_rf_we | input | 1 | Normally decoded register write enable |
| f_rf_dst | input | 5 | Normally decoded destination register |
| rs_val | input | 32 | Forwarded first operand of the decode instruction |
| rt_val | input | 32 | Forwarded second operand of the decode instruction |
| br_taken | output | 1 | Branch is taken |
| br_target | output | 32 | Branch target address |
| next_pc | output | 32 | Redirect address for fetch |
| e_rf_we | output | 1 | Write enable passed to the execute register |
| e_rf_dst | output | 5 | Destination passed to the execute register |
| e_wb_pc8 | output | 1 | Writeback selects PC+8 as data |
| d_flush | output | 1 | Clear of the decode pipeline register |

## Verification
The assertions check, on every cycle, that the clear never coincides with a stall, that a clear leaves the stage empty, and that a stall freezes the decode register. They also check that an empty stage drives nothing and that a taken branch redirects to its target. Some behaviour shows only over a sequence of cycles, and only the bench scenarios reveal it. One example is a nullifying branch that falls through under a stall, whose slot is discarded only once the stall lifts. Others are the exact write enable of a conditional link for each condition code, and the offset arithmetic at negative offsets.

// File: rtl/bl_pkg.sv
package bl_pkg;
    typedef enum logic [1:0] {
        K_PLAIN    = 2'b00,
        K_BR_LINK  = 2'b01,
        K_BR_CLINK = 2'b10,
        K_BR_NULL  = 2'b11
    } kind_e;

    typedef enum logic [1:0] {
        C_EQ    = 2'b00,
        C_NE    = 2'b01,
        C_LTZ   = 2'b10,
        C_NEVER = 2'b11
    } cond_e;

    typedef enum logic {
        DS_BUBBLE = 1'b0,
        DS_LIVE   = 1'b1
    } dstate_e;
endpackage

// File: rtl/bl_cmp.sv
module bl_cmp #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [1:0]      cond,
    output logic            hit
);
    import bl_pkg::*;

    always_comb begin
        unique case (cond_e'(cond))
            C_EQ:    hit = (a == b);
            C_NE:    hit = (a != b);
            C_LTZ:   hit = a[XLEN-1];
            C_NEVER: hit = 1'b0;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/bl_target.sv
module bl_target #(
    parameter int XLEN = 32,
    parameter int OFFW = 16
) (
    input  logic [XLEN-1:0] pc,
    input  logic [OFFW-1:0] off,
    output logic [XLEN-1:0] seq_pc,
    output logic [XLEN-1:0] tgt
);
    localparam int SEXT = XLEN - OFFW - 2;

    always_comb begin
        seq_pc = pc + XLEN'(4);
        tgt    = seq_pc + {{SEXT{off[OFFW-1]}}, off, 2'b00};
    end
endmodule

// File: rtl/bl_dreg.sv
module bl_dreg #(
    parameter int XLEN = 32,
    parameter int RIDX = 5,
    parameter int OFFW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stall,
    input  logic            clr,
    input  logic            f_valid,
    input  logic [1:0]      f_kind,
    input  logic [1:0]      f_cond,
    input  logic [OFFW-1:0] f_off,
    input  logic [XLEN-1:0] f_pc,
    input  logic            f_we,
    input  logic [RIDX-1:0] f_dst,
    output logic            live,
    output logic [1:0]      q_kind,
    output logic [1:0]      q_cond,
    output logic [OFFW-1:0] q_off,
    output logic [XLEN-1:0] q_pc,
    output logic            q_we,
    output logic [RIDX-1:0] q_dst
);
    import bl_pkg::*;

    dstate_e state, state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= DS_BUBBLE;
        else     state <= state_nx;
    end

    // transitions: LOAD, DRAIN, NULLIFY, HOLD
    always_comb begin
        state_nx = state;
        unique case (state)
            DS_BUBBLE: if (!stall && f_valid) state_nx = DS_LIVE;
            DS_LIVE: begin
                if (clr)                      state_nx = DS_BUBBLE;
                else if (!stall && !f_valid)  state_nx = DS_BUBBLE;
            end
            default: state_nx = DS_BUBBLE;
        endcase
    end

    // payload; clear is an extra synchronous-reset term
    always_ff @(posedge clk) begin
        if (rst || clr || (!stall && !f_valid)) begin
            q_kind <= '0;
            q_cond <= '0;
            q_off  <= '0;
            q_pc   <= '0;
            q_we   <= 1'b0;
            q_dst  <= '0;
        end else if (!stall) begin
            q_kind <= f_kind;
            q_cond <= f_cond;
            q_off  <= f_off;
            q_pc   <= f_pc;
            q_we   <= f_we;
            q_dst  <= f_dst;
        end
    end

    assign live = (state == DS_LIVE);

    // R9
    clear_to_bubble_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (state == DS_BUBBLE));

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (stall && !clr) |=> ($stable(state) && $stable(q_pc) && $stable(q_kind)
                             && $stable(q_cond) && $stable(q_off)));
endmodule

// File: rtl/bl_decode_ctrl.sv
module bl_decode_ctrl #(
    parameter int XLEN     = 32,
    parameter int RIDX     = 5,
    parameter int OFFW     = 16,
    parameter int LINK_REG = 31
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stall,
    input  logic            f_valid,
    input  logic [1:0]      f_kind,
    input  logic [1:0]      f_cond,
    input  logic [OFFW-1:0] f_offset,
    input  logic [XLEN-1:0] f_pc,
    input  logic            f_rf_we,
    input  logic [RIDX-1:0] f_rf_dst,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    output logic            br_taken,
    output logic [XLEN-1:0] br_target,
    output logic [XLEN-1:0] next_pc,
    output logic            e_rf_we,
    output logic [RIDX-1:0] e_rf_dst,
    output logic            e_wb_pc8,
    output logic            d_flush
);
    import bl_pkg::*;

    localparam logic [RIDX-1:0] LINK_IDX = RIDX'(LINK_REG);

    logic            live;
    logic [1:0]      q_kind, q_cond;
    logic [OFFW-1:0] q_off;
    logic [XLEN-1:0] q_pc, seq_pc;
    logic            q_we;
    logic [RIDX-1:0] q_dst;
    logic            hit;

    bl_dreg #(.XLEN(XLEN), .RIDX(RIDX), .OFFW(OFFW)) u_dreg (
        .clk(clk), .rst(rst), .stall(stall), .clr(d_flush),
        .f_valid(f_valid), .f_kind(f_kind), .f_cond(f_cond), .f_off(f_offset),
        .f_pc(f_pc), .f_we(f_rf_we), .f_dst(f_rf_dst),
        .live(live), .q_kind(q_kind), .q_cond(q_cond), .q_off(q_off),
        .q_pc(q_pc), .q_we(q_we), .q_dst(q_dst)
    );

    bl_cmp #(.XLEN(XLEN)) u_cmp (
        .a(rs_val), .b(rt_val), .cond(q_cond), .hit(hit)
    );

    bl_target #(.XLEN(XLEN), .OFFW(OFFW)) u_tgt (
        .pc(q_pc), .off(q_off), .seq_pc(seq_pc), .tgt(br_target)
    );

    // output process: decisions per class of the live instruction
    always_comb begin
        br_taken = 1'b0;
        e_rf_we  = 1'b0;
        e_rf_dst = q_dst;
        e_wb_pc8 = 1'b0;
        d_flush  = 1'b0;
        if (live) begin
            unique case (kind_e'(q_kind))
                K_PLAIN: begin
                    e_rf_we = q_we;
                end
                K_BR_LINK: begin
                    br_taken = hit;
                    e_rf_we  = 1'b1;
                    e_rf_dst = LINK_IDX;
                    e_wb_pc8 = 1'b1;
                end
                K_BR_CLINK: begin
                    br_taken = hit;
                    e_rf_we  = hit;
                    e_rf_dst = LINK_IDX;
                    e_wb_pc8 = 1'b1;
                end
                K_BR_NULL: begin
                    br_taken = hit;
                    e_rf_we  = q_we;
                    d_flush  = !hit && !stall;
                end
                default: ;
            endcase
        end
        next_pc = br_taken ? br_target : seq_pc;
    end

    // R8
    flush_stall_chk: assert property (@(posedge clk) disable iff (rst)
        d_flush |-> !stall);

    // R4
    link_uncond_chk: assert property (@(posedge clk) disable iff (rst)
        (live && q_kind == 2'b01) |-> (e_rf_we && e_rf_dst == LINK_IDX && e_wb_pc8));

    // R11
    bubble_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !live |-> (!br_taken && !e_rf_we && !e_wb_pc8 && !d_flush));

    // R3
    redirect_chk: assert property (@(posedge clk) disable iff (rst)
        br_taken |-> (next_pc == br_target));
endmodule

// File: tb/tb_bl_decode_ctrl.sv
module tb_bl_decode_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stall = 1'b0, f_valid = 1'b0, f_rf_we = 1'b0;
    logic [1:0]  f_kind = '0, f_cond = '0;
    logic [15:0] f_offset = '0;
    logic [31:0] f_pc = '0, rs_val = '0, rt_val = '0;
    logic [4:0]  f_rf_dst = '0;
    logic        br_taken, e_rf_we, e_wb_pc8, d_flush;
    logic [31:0] br_target, next_pc;
    logic [4:0]  e_rf_dst;

    int n_cmp = 0, n_bad = 0;

    // bench model of the decode stage
    logic        m_live = 1'b0, m_we = 1'b0;
    logic [1:0]  m_kind = '0, m_cond = '0;
    logic [15:0] m_off = '0;
    logic [31:0] m_pc = '0;
    logic [4:0]  m_dst = '0;

    always #5 clk = ~clk;

    bl_decode_ctrl dut (
        .clk(clk), .rst(rst), .stall(stall), .f_valid(f_valid), .f_kind(f_kind),
        .f_cond(f_cond), .f_offset(f_offset), .f_pc(f_pc), .f_rf_we(f_rf_we),
        .f_rf_dst(f_rf_dst), .rs_val(rs_val), .rt_val(rt_val),
        .br_taken(br_taken), .br_target(br_target), .next_pc(next_pc),
        .e_rf_we(e_rf_we), .e_rf_dst(e_rf_dst), .e_wb_pc8(e_wb_pc8), .d_flush(d_flush)
    );

    function automatic logic f_cmp(logic [1:0] c, logic [31:0] a, logic [31:0] b);
        case (c)
            2'b00:   return a == b;
            2'b01:   return a != b;
            2'b10:   return $signed(a) < 0;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] f_tgt(logic [31:0] pc, logic [15:0] off);
        return pc + 32'd4 + ($signed({{16{off[15]}}, off}) * 4);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(logic st, logic fv, logic [1:0] k, logic [1:0] c,
                        logic [15:0] off, logic [31:0] pc, logic we, logic [4:0] dst,
                        logic [31:0] a, logic [31:0] b);
        logic cv, tk, xwe, xpc8, xfl;
        @(negedge clk);
        stall = st; f_valid = fv; f_kind = k; f_cond = c; f_offset = off;
        f_pc = pc; f_rf_we = we; f_rf_dst = dst; rs_val = a; rt_val = b;
        #1;
        cv   = m_live && f_cmp(m_cond, a, b);
        tk   = m_live && (m_kind != 2'b00) && cv;
        xwe  = !m_live ? 1'b0 : (m_kind == 2'b01) ? 1'b1 : (m_kind == 2'b10) ? cv : m_we;
        xpc8 = m_live && (m_kind == 2'b01 || m_kind == 2'b10);
        xfl  = m_live && (m_kind == 2'b11) && !cv && !st;
        if (!m_live) begin
            chk("R11 bubble taken", 32'(br_taken), 32'(0));
            chk("R11 bubble flush", 32'(d_flush), 32'(0));
            chk("R11 bubble we", 32'(e_rf_we), 32'(0));
        end else begin
            case (m_kind)
                2'b00: chk("R6 plain we", 32'(e_rf_we), 32'(xwe));
                2'b01: chk("R4 link we", 32'(e_rf_we), 32'(xwe));
                2'b10: chk("R5 cond link we", 32'(e_rf_we), 32'(xwe));
                default: chk("R7 null flush", 32'(d_flush), 32'(xfl));
            endcase
            chk("R2 taken", 32'(br_taken), 32'(tk));
            chk("R3 target", br_target, f_tgt(m_pc, m_off));
            chk("R3 next_pc", next_pc, tk ? f_tgt(m_pc, m_off) : m_pc + 32'd4);
            chk("R5 pc8 select", 32'(e_wb_pc8), 32'(xpc8));
            chk("R4 link dst", 32'(e_rf_dst), 32'(xpc8 ? 5'd31 : m_dst));
            if (st) chk("R8 no flush in stall", 32'(d_flush), 32'(0));
            else    chk("R7 flush", 32'(d_flush), 32'(xfl));
        end
        // model update at the coming edge
        if (xfl) begin
            m_live = 1'b0; m_kind = '0; m_cond = '0; m_off = '0; m_pc = '0; m_we = 0; m_dst = '0;
        end else if (!st) begin
            m_live = fv;
            m_kind = fv ? k : 2'b00; m_cond = fv ? c : 2'b00; m_off = fv ? off : 16'd0;
            m_pc = fv ? pc : 32'd0; m_we = fv && we; m_dst = fv ? dst : 5'd0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 taken", 32'(br_taken), 32'(0));
        chk("R1 we", 32'(e_rf_we), 32'(0));
        chk("R1 pc8", 32'(e_wb_pc8), 32'(0));
        chk("R1 flush", 32'(d_flush), 32'(0));

        // R4: link branch, not taken, still links
        step(0, 1, 2'b01, 2'b00, 16'h0010, 32'h0000_1000, 0, 5'd3, 0, 0);
        step(0, 1, 2'b00, 2'b00, 16'h0000, 32'h0000_1004, 1, 5'd7, 32'd1, 32'd2);
        // R5: conditional link, taken then not taken, negative offset
        step(0, 1, 2'b10, 2'b10, 16'hFFFC, 32'h0000_2000, 0, 5'd0, 0, 0);
        step(0, 1, 2'b10, 2'b10, 16'h8000, 32'h0000_2004, 0, 5'd0, 32'h8000_0000, 0);
        step(0, 1, 2'b00, 2'b00, 16'h0000, 32'h0000_2008, 0, 5'd0, 32'd5, 0);
        // R7/R9: nullifying branch falls through, slot discarded
        step(0, 1, 2'b11, 2'b00, 16'h0020, 32'h0000_3000, 0, 5'd0, 0, 0);
        step(0, 1, 2'b00, 2'b00, 16'h0000, 32'h0000_3004, 1, 5'd9, 32'd1, 32'd2);
        step(0, 1, 2'b00, 2'b00, 16'h0000, 32'h0000_3008, 1, 5'd9, 0, 0);
        // R8/R10: nullifying branch under stall, flush after stall ends
        step(0, 1, 2'b11, 2'b01, 16'h0004, 32'h0000_4000, 0, 5'd0, 0, 0);
        step(1, 1, 2'b00, 2'b00, 16'h0000, 32'h0000_4004, 1, 5'd4, 32'd6, 32'd6);
        step(1, 1, 2'b00, 2'b00, 16'h0000, 32'h0000_4004, 1, 5'd4, 32'd6, 32'd6);
        step(0, 1, 2'b00, 2'b00, 16'h0000, 32'h0000_4004, 1, 5'd4, 32'd6, 32'd6);
        step(0, 0, 2'b00, 2'b00, 16'h0000, 32'h0000_4008, 0, 5'd0, 0, 0);
        // R2: never-true code
        step(0, 1, 2'b01, 2'b11, 16'h0001, 32'h0000_5000, 0, 5'd0, 0, 0);
        step(0, 0, 2'b00, 2'b00, 16'h0000, 32'h0, 0, 5'd0, 0, 0);

        for (int i = 0; i < 600; i++) begin
            logic [31:0] a, b;
            int mode;
            mode = $urandom_range(0, 2);
            a = $urandom;
            b = (mode == 0) ? a : (mode == 1) ? 32'($urandom_range(0, 3)) : $urandom;
            step(($urandom_range(0, 3) == 0), ($urandom_range(0, 4) != 0),
                 2'($urandom), 2'($urandom), 16'($urandom),
                 {$urandom, 2'b00} >> 2 << 2, 1'($urandom), 5'($urandom), a, b);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule